// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block takes one fast input clock and produces two banks of divided clocks. Bank A drives two complementary output pairs and bank B drives four. Each bank has its own 2-bit ratio select and its own run enable. Bank A offers an odd ratio (÷5), and that ratio still gives a 50% duty cycle. A high-speed reference, such as an oscillator-locked VCO at 1562.5 MHz, feeds the block. At that input rate the block yields 390.625, 312.5, 195.3125, 156.25 or 97.65625 MHz.

Each bank has its own three-state controller:
- **PARK**: the true outputs are held low.
- **HIGH**: the output high phase, lasting ⌊N/2⌋ input cycles.
- **LOW**: the output low phase, lasting ⌈N/2⌉ input cycles.

The transitions are:
- **start**: PARK→HIGH, when the enable is sampled high.
- **half**: HIGH→LOW, at the end of the high count.
- **wrap**: LOW→HIGH, at the end of the low count with the enable high.
- **stop**: LOW→PARK, at the end of the low count with the enable low.

The ratio select and the enable are sampled only on the start and wrap transitions. For the odd ratio, a copy of the high phase is retimed on the falling input edge and ORed into the output. This stretches the high time to 2.5 input cycles.

A shared active-high reset acts asynchronously. It forces every bank into PARK. Every true output goes low and every complement output goes high. Board integration is expected to tie the enables active and the selects to 00 for bank A and 10 for bank B when they are left unconnected.

Top module: `dual_bank_divider`

## Requirements
- R1: Bank A ratio select decodes 00→÷4, 01→÷5, 10→÷8, 11→÷16 input cycles per output period.
- R2: Bank B ratio select decodes 00→÷4, 01→÷8, 10→÷10, 11→÷16 input cycles per output period.
- R3: The two banks run from separate selects and enables, so each bank may use a different ratio at the same time without affecting the other.
- R4: While the reset is high (asynchronously, from its assertion), every true output is low and every complement output is high.
- R5: For each ratio N the true output is high for N input half-periods and low for N half-periods; for ÷5 the high phase spans 2.5 input cycles, ending on a falling input edge.
- R6: When a bank's enable is low at the end of a LOW phase, that bank parks with true outputs low; a period already started always completes, so no shortened high pulse appears.
- R7: A select change takes effect only at a period boundary (start or wrap), so every output period has entirely the old or entirely the new ratio.
- R8: All true outputs within a bank are identical at every sample.
- R9: Each complement output is the inverse of its true output at every sample.
- R10: From PARK, or after reset release, the true outputs go high in the half-period right after the first rising input edge at which the enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast input clock to be divided |
| hard_rst | input | 1 | Active-high asynchronous reset for both banks |
| ratio_a | input | 2 | Bank A ratio select |
| ratio_b | input | 2 | Bank B ratio select |
| run_a | input | 1 | Bank A enable, sampled at period boundaries |
| run_b | input | 1 | Bank B enable, sampled at period boundaries |
| a_true | output | 2 | Bank A true clock outputs |
| a_comp | output | 2 | Bank A complement clock outputs |
| b_true | output | 4 | Bank B true clock outputs |
| b_comp | output | 4 | Bank B complement clock outputs |

## Verification
The bench samples both outputs once in every input half-period and compares them with a half-period model of each bank.

It targets the following corner cases:
- **Odd ÷5 duty cycle.** A design that dropped the falling-edge extension would give a 2-cycle high and a 3-cycle low.
- **Select changes in the middle of a period.** A design that reloaded at once would emit a period of mixed or truncated length.
- **Enable drops during a high phase.** A design that stopped at once would leave a runt pulse.
- **Reset asserted mid-run.** A design with synchronous or wrong-polarity reset would show a high true output, or a low complement, in the half-period after assertion.

Random select and enable traffic on both banks at once checks that one bank's ratio never leaks into the other.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    // Period controller phases shared by every bank
    typedef enum logic [1:0] {
        S_PARK = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2
    } phase_t;

    // Which ratio set a bank decodes
    typedef enum logic {
        RSET_A = 1'b0,
        RSET_B = 1'b1
    } rset_t;

    localparam int unsigned RATIO_W = 5;

    // Select to ratio (input cycles per output period)
    function automatic logic [RATIO_W-1:0] ratio_of(input rset_t set, input logic [1:0] sel);
        logic [RATIO_W-1:0] r;
        if (set == RSET_A) begin
            unique case (sel)
                2'b00:   r = 5'd4;
                2'b01:   r = 5'd5;
                2'b10:   r = 5'd8;
                default: r = 5'd16;
            endcase
        end else begin
            unique case (sel)
                2'b00:   r = 5'd4;
                2'b01:   r = 5'd8;
                2'b10:   r = 5'd10;
                default: r = 5'd16;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_ratio_dec.sv
`timescale 1ns/1ps
module clkdiv_ratio_dec
    import clkdiv_pkg::*;
#(
    parameter rset_t       RSET  = RSET_A,
    parameter int unsigned LEN_W = 4
) (
    input  logic [1:0]       sel,
    output logic [LEN_W-1:0] hi_len,
    output logic [LEN_W-1:0] lo_len,
    output logic             odd
);

    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] half_floor;

    always_comb begin
        ratio      = ratio_of(RSET, sel);
        half_floor = ratio >> 1;
        // High phase takes the floor half, low phase the remainder
        hi_len     = LEN_W'(half_floor);
        lo_len     = LEN_W'(ratio - half_floor);
        odd        = ratio[0];
    end

endmodule

// File: rtl/clkdiv_bank_fsm.sv
`timescale 1ns/1ps
module clkdiv_bank_fsm
    import clkdiv_pkg::*;
#(
    parameter rset_t       RSET  = RSET_A,
    parameter int unsigned LEN_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       phase_out
);

    logic [LEN_W-1:0] dec_hi;
    logic [LEN_W-1:0] dec_lo;
    logic             dec_odd;

    clkdiv_ratio_dec #(
        .RSET  (RSET),
        .LEN_W (LEN_W)
    ) u_dec (
        .sel    (sel),
        .hi_len (dec_hi),
        .lo_len (dec_lo),
        .odd    (dec_odd)
    );

    phase_t           st_q;
    phase_t           st_d;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cnt_d;
    logic [LEN_W-1:0] hi_len_q;
    logic [LEN_W-1:0] lo_len_q;
    logic             odd_q;
    logic             load;
    logic             hi_last;
    logic             lo_last;
    logic             hi_q;
    logic             fall_q;

    assign hi_last = (cnt_q == hi_len_q - 1'b1);
    assign lo_last = (cnt_q == lo_len_q - 1'b1);

    // Next-state decode: select and enable are looked at only on start/wrap
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        load  = 1'b0;
        unique case (st_q)
            S_PARK: begin
                if (en) begin
                    st_d  = S_HIGH;   // start
                    cnt_d = '0;
                    load  = 1'b1;
                end
            end
            S_HIGH: begin
                if (hi_last) begin
                    st_d  = S_LOW;    // half
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_LOW: begin
                if (lo_last) begin
                    cnt_d = '0;
                    if (en) begin
                        st_d = S_HIGH; // wrap
                        load = 1'b1;
                    end else begin
                        st_d = S_PARK; // stop
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = S_PARK;
                cnt_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q  <= S_PARK;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Period parameters, reloaded only at a boundary
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hi_len_q <= '0;
            lo_len_q <= '0;
            odd_q    <= 1'b0;
        end else if (load) begin
            hi_len_q <= dec_hi;
            lo_len_q <= dec_lo;
            odd_q    <= dec_odd;
        end
    end

    // Output process: rising-edge phase and its falling-edge copy
    always_ff @(posedge clk or posedge rst) begin
        if (rst) hi_q <= 1'b0;
        else     hi_q <= (st_d == S_HIGH);
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= hi_q;
    end

    assign phase_out = hi_q | (odd_q & fall_q);

    AST_HIGH_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_HIGH) |-> (cnt_q < hi_len_q))
        else $error("high count past its length"); // R1

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_HIGH) |=> ($stable(hi_len_q) && $stable(lo_len_q) && $stable(odd_q)))
        else $error("ratio changed inside a period"); // R7

    AST_NO_RUNT_STOP: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_HIGH) |=> (st_q != S_PARK))
        else $error("parked out of a high phase"); // R6

    AST_DUTY_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (st_q != S_PARK) |-> (odd_q ? (lo_len_q == hi_len_q + 1'b1) : (lo_len_q == hi_len_q)))
        else $error("phase lengths not balanced"); // R5

    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_PARK && $past(st_q) == S_PARK) |-> !phase_out)
        else $error("output high while parked"); // R6

endmodule

// File: rtl/clkdiv_fanout.sv
`timescale 1ns/1ps
module clkdiv_fanout #(
    parameter int unsigned PAIRS = 2
) (
    input  logic             phase,
    output logic [PAIRS-1:0] q_true,
    output logic [PAIRS-1:0] q_comp
);

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign q_true[i] = phase;
        assign q_comp[i] = ~phase;
    end

endmodule

// File: rtl/dual_bank_divider.sv
`timescale 1ns/1ps
module dual_bank_divider
    import clkdiv_pkg::*;
#(
    parameter int unsigned A_PAIRS   = 2,
    parameter int unsigned B_PAIRS   = 4,
    parameter int unsigned MAX_RATIO = 16
) (
    input  logic               fast_clk,
    input  logic               hard_rst,
    input  logic [1:0]         ratio_a,
    input  logic [1:0]         ratio_b,
    input  logic               run_a,
    input  logic               run_b,
    output logic [A_PAIRS-1:0] a_true,
    output logic [A_PAIRS-1:0] a_comp,
    output logic [B_PAIRS-1:0] b_true,
    output logic [B_PAIRS-1:0] b_comp
);

    localparam int unsigned LEN_W = $clog2(MAX_RATIO / 2 + 1);

    logic phase_a;
    logic phase_b;

    clkdiv_bank_fsm #(.RSET(RSET_A), .LEN_W(LEN_W)) u_bank_a (
        .clk       (fast_clk),
        .rst       (hard_rst),
        .en        (run_a),
        .sel       (ratio_a),
        .phase_out (phase_a)
    );

    clkdiv_bank_fsm #(.RSET(RSET_B), .LEN_W(LEN_W)) u_bank_b (
        .clk       (fast_clk),
        .rst       (hard_rst),
        .en        (run_b),
        .sel       (ratio_b),
        .phase_out (phase_b)
    );

    clkdiv_fanout #(.PAIRS(A_PAIRS)) u_fan_a (
        .phase  (phase_a),
        .q_true (a_true),
        .q_comp (a_comp)
    );

    clkdiv_fanout #(.PAIRS(B_PAIRS)) u_fan_b (
        .phase  (phase_b),
        .q_true (b_true),
        .q_comp (b_comp)
    );

    AST_RESET_FORCE: assert property (@(posedge fast_clk)
        hard_rst |-> (a_true == '0 && a_comp == '1 && b_true == '0 && b_comp == '1))
        else $error("outputs not forced by reset"); // R4

    AST_BANK_UNIFORM: assert property (@(posedge fast_clk) disable iff (hard_rst)
        ((a_true == '0 || a_true == '1) && (b_true == '0 || b_true == '1)))
        else $error("pairs within a bank disagree"); // R8

endmodule

// File: tb/dual_bank_divider_test.sv
`timescale 1ns/1ps
module dual_bank_divider_test;

    logic       clk = 1'b0;
    logic       hard_rst;
    logic [1:0] ratio_a, ratio_b;
    logic       run_a, run_b;
    logic [1:0] a_true, a_comp;
    logic [3:0] b_true, b_comp;

    int checks = 0;
    int errors = 0;
    string tag_a = "R4";
    string tag_b = "R4";

    // Half-period model state per bank
    bit park_a = 1'b1, park_b = 1'b1;
    int n_a = 4, n_b = 10;
    int h_a = 0, h_b = 0;

    always #5 clk = ~clk;

    dual_bank_divider uut (
        .fast_clk (clk),
        .hard_rst (hard_rst),
        .ratio_a  (ratio_a),
        .ratio_b  (ratio_b),
        .run_a    (run_a),
        .run_b    (run_b),
        .a_true   (a_true),
        .a_comp   (a_comp),
        .b_true   (b_true),
        .b_comp   (b_comp)
    );

    // R1 ratio set
    function automatic int exp_ratio_a(logic [1:0] s);
        case (s)
            2'b00: return 4;
            2'b01: return 5;
            2'b10: return 8;
            default: return 16;
        endcase
    endfunction

    // R2 ratio set
    function automatic int exp_ratio_b(logic [1:0] s);
        case (s)
            2'b00: return 4;
            2'b01: return 8;
            2'b10: return 10;
            default: return 16;
        endcase
    endfunction

    // Advance one bank's model at a rising edge (R7 reload, R6 park, R10 start)
    task automatic model_bank(input logic en, input int ratio,
                              inout bit park, inout int n, inout int h);
        if (hard_rst) begin
            park = 1'b1;
        end else if (park || (h + 2 >= 2 * n)) begin
            if (en) begin
                n = ratio; h = 0; park = 1'b0;
            end else begin
                park = 1'b1;
            end
        end else begin
            h = h + 2;
        end
    endtask

    // R5: high for the first N half-periods of an N-cycle period
    function automatic bit exp_level(bit park, int n, int h, int half);
        if (park) return 1'b0;
        return (h + half) < n;
    endfunction

    task automatic compare(input int half);
        bit ea, eb;
        ea = exp_level(park_a, n_a, h_a, half);
        eb = exp_level(park_b, n_b, h_b, half);
        checks++;
        if (a_true !== {2{ea}}) begin
            errors++;
            $display("FAIL %s/R8 bank A true got %b expected %b at %0t", tag_a, a_true, {2{ea}}, $time);
        end
        checks++;
        if (a_comp !== ~{2{ea}}) begin
            errors++;
            $display("FAIL R9 bank A comp got %b expected %b at %0t", a_comp, ~{2{ea}}, $time);
        end
        checks++;
        if (b_true !== {4{eb}}) begin
            errors++;
            $display("FAIL %s/R8 bank B true got %b expected %b at %0t", tag_b, b_true, {4{eb}}, $time);
        end
        checks++;
        if (b_comp !== ~{4{eb}}) begin
            errors++;
            $display("FAIL R9 bank B comp got %b expected %b at %0t", b_comp, ~{4{eb}}, $time);
        end
    endtask

    // One input cycle; inputs change only after this returns
    task automatic step();
        @(posedge clk);
        model_bank(run_a, exp_ratio_a(ratio_a), park_a, n_a, h_a);
        model_bank(run_b, exp_ratio_b(ratio_b), park_b, n_b, h_b);
        #2.5;
        compare(0);
        @(negedge clk);
        #2.5;
        compare(1);
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) step();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired, expected run to finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        hard_rst = 1'b1;
        ratio_a  = 2'b00;
        ratio_b  = 2'b10;
        run_a    = 1'b1;
        run_b    = 1'b1;

        // R4: reset state before any clock edge
        #1;
        checks++;
        if (a_true !== 2'b00 || a_comp !== 2'b11 || b_true !== 4'h0 || b_comp !== 4'hF) begin
            errors++;
            $display("FAIL R4 reset state got %b %b %b %b expected 00 11 0000 1111",
                     a_true, a_comp, b_true, b_comp);
        end
        run(4);

        // R10: release, start on the first edge
        hard_rst = 1'b0;
        tag_a = "R10"; tag_b = "R10";
        run(12);

        // R1 / R2 / R3: different ratios on each bank at once; R5 on the odd ratio
        for (int i = 0; i < 4; i++) begin
            ratio_a = 2'(i);
            ratio_b = 2'(3 - i);
            tag_a = (i == 1) ? "R5" : "R1";
            tag_b = "R2";
            run(50);
        end

        // R6: enable dropped during a high phase, then restored (R10)
        ratio_a = 2'b01; ratio_b = 2'b00;
        run(7);
        tag_a = "R6"; tag_b = "R6";
        step();
        run_a = 1'b0;
        run(13);
        run_b = 1'b0;
        run(20);
        tag_a = "R10"; tag_b = "R10";
        run_a = 1'b1; run_b = 1'b1;
        run(20);

        // R7 / R3: random selects and enables on both banks
        tag_a = "R7"; tag_b = "R7";
        for (int i = 0; i < 700; i++) begin
            if ($urandom_range(3) == 0) ratio_a = 2'($urandom_range(3));
            if ($urandom_range(3) == 0) ratio_b = 2'($urandom_range(3));
            run_a = ($urandom_range(7) != 0);
            run_b = ($urandom_range(7) != 0);
            step();
        end

        // R4: reset in the middle of a run, then R10 restart
        run_a = 1'b1; run_b = 1'b1;
        ratio_a = 2'b01; ratio_b = 2'b10;
        run(6);
        tag_a = "R4"; tag_b = "R4";
        hard_rst = 1'b1;
        run(3);
        hard_rst = 1'b0;
        tag_a = "R10"; tag_b = "R10";
        run(30);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule